// File: doc/BRIEF.md
# Lockable Peripheral Clock Channel Bank

This block holds one small control register per peripheral clock channel on a word-addressed register bus. Each register names the clock generator that feeds its channel, switches the channel on or off, and carries a sticky write-lock bit. When the lock bit is set, the register no longer accepts writes. The generator the register names is then reported as locked on a per-generator vector, so the generator's own control register can refuse writes too. Generator 0 is never reported this way.

Two synchronous active-low resets act on the bank. The power reset clears every register, including the lock bits. The user reset clears the select and enable fields only in channels that are not locked. The bank drives each channel's generator select, a flag that says whether the select names a real generator, and the enable. Clock multiplexing itself lives elsewhere.

Top module: `pclk_chan_bank`

## Requirements
- R1: While `por_n` is low at a clock edge, every channel's select, enable and lock become zero, `gen_lock` reads all zero, and `bus_rdata` becomes zero.
- R2: Channel m answers at byte address 0x80 + 4*m for m from 0 to 47. Any other address, including unaligned ones (address bits 1:0 not zero), reads as zero and is ignored on write.
- R3: A register reads with the select in bits 3:0, the enable in bit 6 and the lock in bit 7, and zeros everywhere else. The read data appears on `bus_rdata` the cycle after `bus_rd` is sampled. It reflects the state before any write in that same cycle. Bits 4, 5 and 8 to 31 of written data are dropped.
- R4: A write to an unlocked channel updates the select, the enable and the lock together in one cycle, so a write that sets the lock also stores its select and enable.
- R5: Once a channel's lock bit is 1, every later write to that channel leaves all of its fields unchanged.
- R6: `gen_lock[n]`, for n from 1 to 11, is high exactly when at least one locked channel has select value n. `gen_lock[0]` stays low even when a locked channel selects generator 0.
- R7: Select values 0xC to 0xF are stored and read back as written. For such a channel, `chan_sel_vld` is low and no `gen_lock` bit is set. For values 0x0 to 0xB, `chan_sel_vld` is high.
- R8: In a cycle where `usr_rst_n` is low and `por_n` is high, every unlocked channel gets a select of 0 and an enable of 0. Locked channels keep all three fields, including the lock.
- R9: Only the power reset clears a lock bit. When both resets are low in the same cycle, the power reset's effect applies. After the power reset, a formerly locked channel accepts writes again.
- R10: When a user reset and a write to an unlocked channel land in the same cycle, the user reset wins and the write is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power reset, synchronous, active low |
| usr_rst_n | input | 1 | User reset, synchronous, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| chan_sel | output | N_CHAN*4 (192) | Generator select per channel, channel m in bits 4m+3:4m |
| chan_en | output | N_CHAN (48) | Channel enable per channel |
| chan_sel_vld | output | N_CHAN (48) | High when the channel's select names an existing generator |
| gen_lock | output | N_GEN (12) | Per-generator lock derived from locked channels |

## Verification
The bench builds the bank with its default parameters: 48 channels, 12 generators, a 12-bit address and a base of 0x80. With these values, the bench can reach both ends of the window. It uses channel 0 at 0x80 and channel 47 at 0x13C, and it probes the first address past the window (0x140), the word below the window (0x7C) and an unaligned address. With twelve generators, the select codes 0xC to 0xF fall outside the generator range. The bench uses them to check the stored-but-invalid path, alongside generator 0 and a mid-range generator under lock.

// File: rtl/pclk_chan_pkg.sv
// Package: shared field layout and register image type for the
// peripheral clock channel bank. Assumes a 32-bit data bus and at most
// sixteen generators (4-bit select).
package pclk_chan_pkg;

    localparam int DATA_W   = 32;
    localparam int SEL_W    = 4;
    localparam int EN_BIT   = 6;
    localparam int LOCK_BIT = 7;

    typedef struct packed {
        logic             lock;
        logic             en;
        logic [SEL_W-1:0] sel;
    } chan_t;

    // Build the read image of one channel register.
    function automatic logic [DATA_W-1:0] chan_to_word(chan_t c);
        logic [DATA_W-1:0] w;
        w               = '0;
        w[SEL_W-1:0]    = c.sel;
        w[EN_BIT]       = c.en;
        w[LOCK_BIT]     = c.lock;
        return w;
    endfunction

    // Extract the stored fields from a write word.
    function automatic chan_t word_to_chan(logic [DATA_W-1:0] w);
        chan_t c;
        c.sel  = w[SEL_W-1:0];
        c.en   = w[EN_BIT];
        c.lock = w[LOCK_BIT];
        return c;
    endfunction

endpackage

// File: rtl/pclk_addr_dec.sv
// Module: address decoder for the channel window.
// Maps a byte address to a channel index. An address hits only when it
// is word aligned and lies inside BASE .. BASE + 4*N_CHAN - 4.
// Assumes ADDR_W leaves room for the index plus the two byte bits.
module pclk_addr_dec #(
    parameter int          N_CHAN = 48,
    parameter int          ADDR_W = 12,
    parameter int unsigned BASE   = 32'h80,
    localparam int         IDX_W  = $clog2(N_CHAN)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] LIMIT  = ADDR_W'(N_CHAN);

    logic [ADDR_W-1:0] off;

    // Offset from the window base and range/alignment test.
    always_comb begin
        off = addr - BASE_A;
        hit = (addr >= BASE_A) && (off[1:0] == 2'b00)
              && ({2'b00, off[ADDR_W-1:2]} < LIMIT);
        idx = off[IDX_W+1:2];
    end

endmodule

// File: rtl/pclk_chan_reg.sv
// Module: one channel control register with a sticky lock.
// The power reset clears everything. The user reset clears the select
// and enable only while unlocked. A write lands only while unlocked.
// Assumes both resets are synchronous and active low.
module pclk_chan_reg
    import pclk_chan_pkg::*;
#(
    parameter int N_GEN = 12
) (
    input  logic  clk,
    input  logic  por_n,
    input  logic  usr_rst_n,
    input  logic  wr_sel,
    input  chan_t wr_val,
    output chan_t q,
    output logic  sel_vld
);

    localparam logic [SEL_W-1:0] GEN_LIM = SEL_W'(N_GEN);

    // Register update with reset priority: power, user, then write.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            q <= '0;
        end else if (!usr_rst_n && !q.lock) begin
            q.sel <= '0;
            q.en  <= 1'b0;
        end else if (wr_sel && !q.lock) begin
            q <= wr_val;
        end
    end

    // Flag selects that name an existing generator.
    always_comb sel_vld = (q.sel < GEN_LIM);

    // R5: a locked channel holds all of its fields until a power reset.
    a_r5_locked_hold: assert property (@(posedge clk) disable iff (!por_n)
        q.lock |=> $stable(q));

    // R4: an accepted write stores all three fields in one step.
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!por_n)
        (usr_rst_n && wr_sel && !q.lock) |=> (q == $past(wr_val)));

    // R8 / R10: a user reset clears an unlocked channel, even with a write.
    a_r8_user_clear: assert property (@(posedge clk) disable iff (!por_n)
        (!usr_rst_n && !q.lock) |=> (q == '0));

endmodule

// File: rtl/pclk_gen_lock.sv
// Module: per-generator lock reduction.
// Bit n is high when any locked channel selects generator n. Generator 0
// is exempt and its bit stays low. Assumes N_GEN fits the select width.
module pclk_gen_lock
    import pclk_chan_pkg::*;
#(
    parameter int N_CHAN = 48,
    parameter int N_GEN  = 12
) (
    input  logic [N_CHAN-1:0]       lock_vec,
    input  logic [N_CHAN*SEL_W-1:0] sel_vec,
    output logic [N_GEN-1:0]        gen_lock
);

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        if (g == 0) begin : g_exempt
            assign gen_lock[g] = 1'b0;
        end else begin : g_or
            logic acc;
            // OR over channels that are locked onto generator g.
            always_comb begin
                acc = 1'b0;
                for (int c = 0; c < N_CHAN; c++) begin
                    acc = acc | (lock_vec[c]
                          && (sel_vec[c*SEL_W +: SEL_W] == SEL_W'(g)));
                end
            end
            assign gen_lock[g] = acc;
        end
    end

endmodule

// File: rtl/pclk_chan_bank.sv
// Module: top of the lockable peripheral clock channel bank.
// It holds N_CHAN channel registers on a word-addressed bus, returns read
// data one cycle after the strobe and drives the per-generator lock
// vector. Assumes synchronous active-low resets and a single shared
// address for reads and writes.
module pclk_chan_bank
    import pclk_chan_pkg::*;
#(
    parameter int          N_CHAN    = 48,
    parameter int          N_GEN     = 12,
    parameter int          ADDR_W    = 12,
    parameter int unsigned BASE_ADDR = 32'h80
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    usr_rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [N_CHAN*SEL_W-1:0] chan_sel,
    output logic [N_CHAN-1:0]       chan_en,
    output logic [N_CHAN-1:0]       chan_sel_vld,
    output logic [N_GEN-1:0]        gen_lock
);

    localparam int IDX_W = $clog2(N_CHAN);

    logic             hit;
    logic [IDX_W-1:0] idx;
    chan_t            wr_val;
    chan_t            chans [N_CHAN];
    logic [N_CHAN-1:0] lock_vec;
    logic [31:0]      rd_mux;
    logic             unused_wdata;

    pclk_addr_dec #(
        .N_CHAN (N_CHAN),
        .ADDR_W (ADDR_W),
        .BASE   (BASE_ADDR)
    ) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    // Field extraction from the write word; spare bits are dropped.
    always_comb wr_val = word_to_chan(bus_wdata);
    assign unused_wdata = ^{bus_wdata[31:8], bus_wdata[5:4]};

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        logic wr_sel;
        // Write strobe for this channel.
        always_comb wr_sel = bus_wr && hit && (idx == IDX_W'(c));

        pclk_chan_reg #(
            .N_GEN (N_GEN)
        ) u_reg (
            .clk       (clk),
            .por_n     (por_n),
            .usr_rst_n (usr_rst_n),
            .wr_sel    (wr_sel),
            .wr_val    (wr_val),
            .q         (chans[c]),
            .sel_vld   (chan_sel_vld[c])
        );

        assign chan_sel[c*SEL_W +: SEL_W] = chans[c].sel;
        assign chan_en[c]                 = chans[c].en;
        assign lock_vec[c]                = chans[c].lock;
    end

    pclk_gen_lock #(
        .N_CHAN (N_CHAN),
        .N_GEN  (N_GEN)
    ) u_glock (
        .lock_vec (lock_vec),
        .sel_vec  (chan_sel),
        .gen_lock (gen_lock)
    );

    // Read image of the addressed channel, zero outside the window.
    always_comb rd_mux = hit ? chan_to_word(chans[idx]) : '0;

    // Registered read port; idle cycles return zero.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end else begin
            bus_rdata <= '0;
        end
    end

    // R2: a read outside the window returns zero next cycle.
    a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rd && !hit) |=> (bus_rdata == '0));

    // R6: a generator lock always traces back to some locked channel.
    a_r6_lock_source: assert property (@(posedge clk) disable iff (!por_n)
        (|gen_lock) |-> (|lock_vec));

    // R3: read data never carries bits outside the defined fields.
    a_r3_spare_zero: assert property (@(posedge clk) disable iff (!por_n)
        bus_rd |=> (bus_rdata[31:8] == '0 && bus_rdata[5:4] == 2'b00));

endmodule

// File: tb/pclk_chan_bank_tb_top.sv
// Bench: scoreboard-based check of the channel bank. The driver tasks push
// expected read words into a queue. A monitor pops and compares them when
// the read data comes out. Output vectors are compared with a bench model
// built from the requirements.
module pclk_chan_bank_tb_top;

    localparam int NC = 48;
    localparam int NG = 12;

    logic         clk = 1'b0;
    logic         por_n, usr_rst_n, bus_wr, bus_rd;
    logic [11:0]  bus_addr;
    logic [31:0]  bus_wdata, bus_rdata;
    logic [NC*4-1:0] chan_sel;
    logic [NC-1:0]   chan_en, chan_sel_vld;
    logic [NG-1:0]   gen_lock;

    int total = 0;
    int bad   = 0;

    logic [3:0] m_sel  [NC];
    logic       m_en   [NC];
    logic       m_lock [NC];

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    pclk_chan_bank dut_i (
        .clk (clk), .por_n (por_n), .usr_rst_n (usr_rst_n),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .chan_sel (chan_sel), .chan_en (chan_en),
        .chan_sel_vld (chan_sel_vld), .gen_lock (gen_lock)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model_por();
        for (int c = 0; c < NC; c++) begin
            m_sel[c] = '0; m_en[c] = 1'b0; m_lock[c] = 1'b0;
        end
    endfunction

    function automatic void model_usr();
        for (int c = 0; c < NC; c++)
            if (!m_lock[c]) begin m_sel[c] = '0; m_en[c] = 1'b0; end
    endfunction

    function automatic void model_write(logic [11:0] a, logic [31:0] d);
        int m;
        if (a[1:0] != 2'b00 || a < 12'h080) return;
        m = int'((a - 12'h080) >> 2);
        if (m >= NC || m_lock[m]) return;
        m_sel[m] = d[3:0]; m_en[m] = d[6]; m_lock[m] = d[7];
    endfunction

    function automatic logic [31:0] model_word(int m);
        return {24'h0, m_lock[m], m_en[m], 2'b00, m_sel[m]};
    endfunction

    function automatic logic [NG-1:0] model_glock();
        logic [NG-1:0] g = '0;
        for (int c = 0; c < NC; c++)
            if (m_lock[c] && m_sel[c] != 4'h0 && m_sel[c] < 4'(NG))
                g[m_sel[c]] = 1'b1;
        return g;
    endfunction

    // Compare every output vector against the model; one check per call.
    task automatic chk_outputs(string tag);
        logic ok = 1'b1;
        total++;
        for (int c = 0; c < NC; c++) begin
            if (chan_sel[c*4 +: 4] !== m_sel[c] || chan_en[c] !== m_en[c]
                || chan_sel_vld[c] !== (m_sel[c] < 4'(NG))) begin
                if (ok) $display("FAIL %s ch%0d actual sel=%h en=%b vld=%b expected sel=%h en=%b vld=%b",
                    tag, c, chan_sel[c*4 +: 4], chan_en[c], chan_sel_vld[c],
                    m_sel[c], m_en[c], (m_sel[c] < 4'(NG)));
                ok = 1'b0;
            end
        end
        if (gen_lock !== model_glock()) begin
            if (ok) $display("FAIL %s gen_lock actual=%h expected=%h",
                tag, gen_lock, model_glock());
            ok = 1'b0;
        end
        if (!ok) bad++;
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [11:0] ch_addr(int m);
        return 12'(12'h080 + 4 * m);
    endfunction

    // Monitor: pop the expected word when a sampled read returns data.
    always begin
        logic pend;
        @(posedge clk);
        pend = bus_rd;
        @(negedge clk);
        if (pend) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R3 unexpected read actual=%h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        por_n = 1'b0; usr_rst_n = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        model_por();
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        chk_outputs("R1 outputs after reset");
        bus_read(ch_addr(0), 32'h0, "R1 ch0 reads zero");
        bus_read(ch_addr(47), 32'h0, "R1 ch47 reads zero");

        // R3/R4: field layout and spare bits dropped.
        bus_write(ch_addr(0), 32'h0000_0043);
        bus_read(ch_addr(0), 32'h43, "R4 ch0 sel3 en");
        bus_write(ch_addr(0), 32'hFFFF_FF35);
        bus_read(ch_addr(0), 32'h05, "R3 spare bits dropped");
        chk_outputs("R3 outputs after write");

        // R4/R6: lock on last channel with generator 7.
        bus_write(ch_addr(47), 32'h0000_00C7);
        bus_read(ch_addr(47), 32'hC7, "R4 lock write stores fields");
        chk("R6 gen7 locked", 32'(gen_lock), 32'h080);
        // R5: later write discarded.
        bus_write(ch_addr(47), 32'h0000_0041);
        bus_read(ch_addr(47), 32'hC7, "R5 locked write ignored");
        chk_outputs("R5 outputs hold");

        // R6: generator 0 never locks.
        bus_write(ch_addr(5), 32'h0000_0080);
        chk("R6 gen0 exempt", 32'(gen_lock), 32'h080);
        // R7: out-of-range select stored, invalid, no lock.
        bus_write(ch_addr(6), 32'h0000_008E);
        bus_read(ch_addr(6), 32'h8E, "R7 select 0xE stored");
        chk("R7 sel_vld low", 32'(chan_sel_vld[6]), 32'h0);
        chk("R7 no gen lock", 32'(gen_lock), 32'h080);
        chk_outputs("R7 outputs");

        // R2: misses ignored on write, read zero.
        bus_write(12'h140, 32'h0000_00C1);
        bus_write(12'h07C, 32'h0000_00C1);
        bus_write(12'h081, 32'h0000_00C1);
        chk_outputs("R2 stray writes ignored");
        bus_read(12'h140, 32'h0, "R2 past window reads zero");
        bus_read(12'h086, 32'h0, "R2 unaligned reads zero");

        // R3: read in the same cycle as a write sees the old value.
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = ch_addr(1); bus_wdata = 32'h42;
        exp_q.push_back(32'h0); tag_q.push_back("R3 read before same-cycle write");
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        model_write(ch_addr(1), 32'h42);
        bus_read(ch_addr(1), 32'h42, "R3 read after write");

        // R8: user reset skips locked channels.
        bus_write(ch_addr(2), 32'h0000_0049);
        @(negedge clk);
        usr_rst_n = 1'b0;
        @(negedge clk);
        usr_rst_n = 1'b1;
        model_usr();
        chk_outputs("R8 user reset");
        bus_read(ch_addr(47), 32'hC7, "R8 locked ch47 kept");
        bus_read(ch_addr(2), 32'h0, "R8 unlocked ch2 cleared");
        bus_read(ch_addr(6), 32'h8E, "R8 locked ch6 kept");

        // R10: user reset beats a same-cycle write.
        @(negedge clk);
        usr_rst_n = 1'b0; bus_wr = 1'b1; bus_addr = ch_addr(3); bus_wdata = 32'h44;
        @(negedge clk);
        usr_rst_n = 1'b1; bus_wr = 1'b0;
        bus_read(ch_addr(3), 32'h0, "R10 write lost to user reset");

        // R9: both resets together, power reset clears locks.
        @(negedge clk);
        por_n = 1'b0; usr_rst_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1; usr_rst_n = 1'b1;
        model_por();
        chk_outputs("R9 power reset clears all");
        chk("R9 gen_lock cleared", 32'(gen_lock), 32'h0);
        bus_write(ch_addr(47), 32'h0000_0042);
        bus_read(ch_addr(47), 32'h42, "R9 unlocked after power reset");

        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule